// File: doc/BRIEF.md
# Requester ID to Stream ID Translation Table

This block turns the 16-bit requester ID of an inbound PCI transaction (bus, device and function packed together) into a stream ID. The stream ID tags the transaction for later stages of the chip. Software fills a 32-entry table through a plain 32-bit register-write port and can read every entry back. Each entry holds four things:

- a requester ID pattern,
- a per-bit don't-care mask,
- the stream ID to return,
- an enable flag.

For each lookup request, the block compares the presented requester ID against all enabled entries at once. One clock later it returns a response flag, a hit flag and the stream ID of the winning entry. When several entries match, the entry with the smallest index wins. This lets software place narrow (exact) entries ahead of wide (masked) fallback entries. When no entry matches, the block returns no hit and a stream ID of zero.

Software writes the pattern register of an entry before the register that carries its enable. An entry therefore never joins the match while it is half written.

Top module: `rid_sid_map`

## Requirements
- R1: A write to address 0x800 + 8*n (n = 0..31, byte address) stores the requester ID pattern from data bits 31:16 and the mask from bits 15:0 of entry n. A read of that address returns the same two fields in the same positions.
- R2: A write to address 0x804 + 8*n stores the stream ID from data bits 15:0 and the enable from bit 31 of entry n. A read of that address returns the enable in bit 31 and the stream ID in bits 15:0. Bits 30:16 always read as zero, whatever was written to them.
- R3: The following writes change no entry: a write below 0x800, a write at 0x900 or above, or a write whose two lowest address bits are not zero. A read of any such address returns zero.
- R4: After reset, every table register reads zero, and every lookup misses.
- R5: Entry n matches requester ID r when it is enabled and (r XOR pattern) AND NOT mask is zero. Mask bit i set to 1 makes requester ID bit i a don't-care. An all-zero mask demands an exact match on all 16 bits.
- R6: An entry with its enable at 0 never matches, whatever its pattern and mask hold.
- R7: When more than one enabled entry matches, the response carries the stream ID of the lowest-numbered matching entry.
- R8: The response flag is high in exactly the cycle after a cycle with a lookup request. A hit is reported only together with the response flag.
- R9: When the request matches no entry, and in any cycle without a response, the hit flag is 0 and the stream ID output is 0.
- R10: A lookup made in the same cycle as a table write sees the table as it was before that write. The write affects lookups from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 12 | Register write byte address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 12 | Register read byte address |
| rd_data | output | 32 | Register read data (combinational from rd_addr) |
| lk_valid | input | 1 | Lookup request |
| lk_rid | input | 16 | Requester ID to translate |
| rsp_valid | output | 1 | Lookup response, one cycle after the request |
| rsp_hit | output | 1 | An enabled entry matched |
| rsp_sid | output | 16 | Stream ID of the winning entry, zero on a miss |

## Verification
The properties assume that the lookup request and the write port are sampled only at rising edges. They also assume that the read address is stable long enough for the combinational readback to settle. The bench honours both: it changes every input on the falling edge and samples outputs one falling edge later.

The properties also assume nothing about table contents. They therefore check only timing, the reserved read-as-zero bits, out-of-range reads and the miss encoding. Match and priority correctness are left to the bench's expected-value table. That table is built by hand from the programmed patterns and masks, including overlapping entries and a disabled entry.

// File: rtl/rsm_pkg.sv
package rsm_pkg;
    localparam int N_ENT    = 32;
    localparam int RID_W    = 16;
    localparam int SID_W    = 16;
    localparam int ADDR_W   = 12;
    localparam int DATA_W   = 32;
    localparam int IDX_W    = $clog2(N_ENT);
    localparam int EN_BIT   = 31;
    localparam logic [ADDR_W-1:0] TBL_BASE = 12'h800;
    localparam logic [ADDR_W-1:0] TBL_SPAN = ADDR_W'(N_ENT * 8);

    typedef struct packed {
        logic             en;
        logic [RID_W-1:0] rid;
        logic [RID_W-1:0] mask;
        logic [SID_W-1:0] sid;
    } entry_t;

    typedef struct packed {
        logic             ok;
        logic             lower;
        logic [IDX_W-1:0] idx;
    } dec_t;

    function automatic dec_t decode(input logic [ADDR_W-1:0] addr);
        dec_t                  r;
        logic [ADDR_W-1:0]     off;
        off     = addr - TBL_BASE;
        r.ok    = (addr >= TBL_BASE) && (off < TBL_SPAN) && (addr[1:0] == 2'b00);
        r.lower = off[2];
        r.idx   = off[IDX_W+2:3];
        return r;
    endfunction
endpackage

// File: rtl/rsm_regbank.sv
module rsm_regbank
    import rsm_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [DATA_W-1:0]          wr_data,
    input  logic [ADDR_W-1:0]          rd_addr,
    output logic [DATA_W-1:0]          rd_data,
    output entry_t [N_ENT-1:0]         ents
);
    entry_t [N_ENT-1:0] tbl_d, tbl_q;
    dec_t               wdec, rdec;
    entry_t             rsel;

    always_comb begin
        tbl_d = tbl_q;
        wdec  = decode(wr_addr);
        if (wr_en && wdec.ok) begin
            if (wdec.lower) begin
                tbl_d[wdec.idx].en  = wr_data[EN_BIT];
                tbl_d[wdec.idx].sid = wr_data[SID_W-1:0];
            end else begin
                tbl_d[wdec.idx].rid  = wr_data[DATA_W-1:DATA_W-RID_W];
                tbl_d[wdec.idx].mask = wr_data[RID_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tbl_q <= '0;
        else        tbl_q <= tbl_d;
    end

    always_comb begin
        rdec    = decode(rd_addr);
        rsel    = tbl_q[rdec.idx];
        rd_data = '0;
        if (rdec.ok) begin
            if (rdec.lower) begin
                rd_data[EN_BIT]      = rsel.en;
                rd_data[SID_W-1:0]   = rsel.sid;
            end else begin
                rd_data = {rsel.rid, rsel.mask};
            end
        end
    end

    assign ents = tbl_q;
endmodule

// File: rtl/rsm_match.sv
module rsm_match
    import rsm_pkg::*;
(
    input  entry_t [N_ENT-1:0] ents,
    input  logic [RID_W-1:0]   rid,
    output logic               any,
    output logic [SID_W-1:0]   sid
);
    logic [N_ENT-1:0] hitv;

    for (genvar i = 0; i < N_ENT; i++) begin : g_cmp
        assign hitv[i] = ents[i].en &&
                         (((rid ^ ents[i].rid) & ~ents[i].mask) == '0);
    end

    always_comb begin
        any = 1'b0;
        sid = '0;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (hitv[i]) begin
                any = 1'b1;
                sid = ents[i].sid;
            end
        end
    end
endmodule

// File: rtl/rid_sid_map.sv
module rid_sid_map
    import rsm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [11:0]       wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [11:0]       rd_addr,
    output logic [31:0]       rd_data,
    input  logic              lk_valid,
    input  logic [15:0]       lk_rid,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [15:0]       rsp_sid
);
    typedef struct packed {
        logic             valid;
        logic             hit;
        logic [SID_W-1:0] sid;
    } rsp_t;

    entry_t [N_ENT-1:0] ents;
    logic               m_any;
    logic [SID_W-1:0]   m_sid;
    rsp_t               rsp_d, rsp_q;

    rsm_regbank u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .ents    (ents)
    );

    rsm_match u_match (
        .ents (ents),
        .rid  (lk_rid),
        .any  (m_any),
        .sid  (m_sid)
    );

    always_comb begin
        rsp_d       = '0;
        rsp_d.valid = lk_valid;
        if (lk_valid && m_any) begin
            rsp_d.hit = 1'b1;
            rsp_d.sid = m_sid;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_hit   = rsp_q.hit;
    assign rsp_sid   = rsp_q.sid;
endmodule

// File: rtl/rsm_chk.sv
module rsm_chk
    import rsm_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic [11:0] rd_addr,
    input logic [31:0] rd_data,
    input logic        lk_valid,
    input logic        rsp_valid,
    input logic        rsp_hit,
    input logic [15:0] rsp_sid
);
    dec_t rd_dec;
    assign rd_dec = decode(rd_addr);

    p_rsp_follows_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rsp_valid);
    p_no_rsp_without_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !rsp_valid);
    p_hit_needs_rsp_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> rsp_valid);
    p_miss_sid_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_hit |-> (rsp_sid == '0));
    p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_dec.ok && rd_dec.lower) |-> (rd_data[30:16] == '0));
    p_oob_read_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_dec.ok |-> (rd_data == '0));
endmodule

bind rid_sid_map rsm_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .lk_valid  (lk_valid),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .rsp_sid   (rsp_sid)
);

// File: tb/sim_rid_sid_map.sv
module sim_rid_sid_map;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 8;
    // {rid[32:17], hit[16], sid[15:0]}
    localparam logic [32:0] VEC [NVEC] = '{
        {16'h0100, 1'b1, 16'h0011},   // R5 exact
        {16'h0101, 1'b0, 16'h0000},   // R5 one bit off, R9 miss
        {16'h020B, 1'b1, 16'h0022},   // R5 masked function bits
        {16'h0208, 1'b1, 16'h0022},   // R7 entries 1,2,4 match; 1 wins
        {16'h02F0, 1'b1, 16'h0033},   // R7 falls to entry 2
        {16'h0300, 1'b0, 16'h0000},   // R6 disabled entry 3
        {16'h0500, 1'b1, 16'h0055},   // R5 last entry
        {16'hFFFF, 1'b0, 16'h0000}    // R9 miss
    };

    logic        clk = 0, rst_n = 0;
    logic        wr_en = 0, lk_valid = 0;
    logic [11:0] wr_addr = 0, rd_addr = 0;
    logic [31:0] wr_data = 0, rd_data;
    logic [15:0] lk_rid = 0, rsp_sid;
    logic        rsp_valid, rsp_hit;
    int          n_chk = 0, n_bad = 0;
    bit          done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rid_sid_map u0 (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic rd(input string req, input logic [11:0] a, input logic [31:0] exp);
        rd_addr = a;
        #1;
        chk(req, rd_data, exp);
    endtask

    task automatic look(input string req, input logic [15:0] r, input logic h, input logic [15:0] s);
        @(negedge clk);
        lk_valid = 1; lk_rid = r;
        @(negedge clk);
        lk_valid = 0;
        chk({req, " valid"}, {31'b0, rsp_valid}, 32'd1);
        chk({req, " hit"}, {31'b0, rsp_hit}, {31'b0, h});
        chk({req, " sid"}, {16'b0, rsp_sid}, {16'b0, s});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R4: reset state
        rd("R4", 12'h800, 0); rd("R4", 12'h804, 0);
        rd("R4", 12'h8F8, 0); rd("R4", 12'h8FC, 0);
        look("R4", 16'h0000, 0, 0);
        // R8: no response without request
        @(negedge clk);
        chk("R8 idle valid", {31'b0, rsp_valid}, 0);
        chk("R9 idle sid", {16'b0, rsp_sid}, 0);

        wr(12'h800, 32'h0100_0000); wr(12'h804, 32'h8000_0011);
        wr(12'h808, 32'h0208_0007); wr(12'h80C, 32'h8000_0022);
        wr(12'h810, 32'h0200_00FF); wr(12'h814, 32'h8000_0033);
        wr(12'h818, 32'h0300_0000); wr(12'h81C, 32'h0000_0044);
        wr(12'h820, 32'h0208_0000); wr(12'h824, 32'h8000_0066);
        wr(12'h8F8, 32'h0500_0000); wr(12'h8FC, 32'h8000_0055);

        // R1/R2 readback
        rd("R1", 12'h808, 32'h0208_0007);
        rd("R1", 12'h8F8, 32'h0500_0000);
        rd("R2", 12'h80C, 32'h8000_0022);
        wr(12'h82C, 32'hFFFF_FFFF);
        rd("R2 reserved", 12'h82C, 32'h8000_FFFF);
        wr(12'h82C, 32'h0000_0000);

        for (int i = 0; i < NVEC; i++)
            look("R5/R6/R7/R9 vector", VEC[i][32:17], VEC[i][16], VEC[i][15:0]);

        // R3: ignored writes, zero reads
        wr(12'h900, 32'hDEAD_BEEF); rd("R3 high", 12'h900, 0);
        wr(12'h7FC, 32'hDEAD_BEEF); rd("R3 low", 12'h7FC, 0);
        wr(12'h801, 32'hFFFF_FFFF); rd("R3 unaligned", 12'h800, 32'h0100_0000);
        rd("R3 unaligned read", 12'h805, 0);
        look("R3 entry0 intact", 16'h0100, 1, 16'h0011);

        // R10: write and lookup in the same cycle
        @(negedge clk);
        wr_en = 1; wr_addr = 12'h81C; wr_data = 32'h8000_0044;
        lk_valid = 1; lk_rid = 16'h0300;
        @(negedge clk);
        wr_en = 0; lk_valid = 0;
        chk("R10 old table hit", {31'b0, rsp_hit}, 0);
        look("R10 new table", 16'h0300, 1, 16'h0044);

        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual timeout expected finish");
            end
        join_any
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule